// File: doc/BRIEF.md
# Deferred Write Buffer Retire Unit

This block models the one-entry write buffer on the device side of a DRAM that receives commands as packets. A write command addressed to this device puts its data, byte mask, bank and column into the buffer. The row is never stored. Later, the buffered write is retired into the array. The retire strobe carries the bank, the column, the data, the mask and the row that is open in that bank at the moment of retire. That row can differ from the row that was open when the write arrived.

A retire normally happens a fixed number of cycles after capture. A read to this device while the write is pending restarts that wait, so a stream of reads can defer the retire for as long as it lasts. A write to a different device forces an immediate retire. A second write to this device that arrives before the first has retired replaces the first, and the first is lost. That loss sets a sticky error flag that stays set until reset.

Top module: `wr_retire_buf`

## Requirements
- R1: While reset is held low, and after it is released, `bufValid`, `retireValid` and `lostWriteErr` are 0. A write that is pending when reset is asserted is discarded and never retires.
- R2: Command codes on `cmdOp` are 2'b00 no-operation, 2'b01 write, 2'b10 read. A write with `cmdValid` high and `cmdDev` equal to DEVICE_ID captures `cmdBank`, `cmdCol`, `wrData` and `wrMask`, and `bufValid` reads 1 from the next cycle.
- R3: With no read to this device and no other command affecting the buffer, `retireValid` pulses for one cycle at the RETIRE_DLY+1-th rising edge after the capture edge. It carries the captured bank, column, data and mask, and `bufValid` drops at that same edge.
- R4: `retireRow` is the slice of `openRows` for the target bank (bank b at bits b*ROW_W upward) as sampled at the edge that registers the retire, and not as sampled at the write.
- R5: Each read to this device while a write is pending restarts the wait. The retire then occurs RETIRE_DLY+1 edges after the last such read, whatever bank and column those reads carry and however many there are.
- R6: A read to another device, or a no-operation, neither delays nor causes a retire.
- R7: A write to another device while a write is pending retires it at that edge, with `retireValid` high in the following cycle, and `bufValid` drops.
- R8: A write to this device while a write is pending, in a cycle where no retire fires, replaces the pending entry. The old entry never retires, and `lostWriteErr` sets and stays set until reset.
- R9: A write to this device in the very cycle a pending write retires lets the old entry retire and captures the new one without setting `lostWriteErr`. The new entry then retires on its own schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A decoded column command is present this cycle |
| cmdOp | input | 2 | Command code: 00 no-op, 01 write, 10 read |
| cmdDev | input | DEV_W | Device the command is addressed to |
| cmdBank | input | BANK_W | Bank of the command |
| cmdCol | input | COL_W | Column of the command |
| wrData | input | DATA_W | Write data, valid with a write command |
| wrMask | input | MASK_W | Byte mask, valid with a write command |
| openRows | input | NUM_BANKS*ROW_W | Row currently active in each bank, bank b at bits b*ROW_W upward |
| retireValid | output | 1 | One-cycle strobe: a buffered write is retiring |
| retireBank | output | BANK_W | Bank of the retiring write |
| retireRow | output | ROW_W | Row the retiring write lands in |
| retireCol | output | COL_W | Column of the retiring write |
| retireData | output | DATA_W | Data of the retiring write |
| retireMask | output | MASK_W | Mask of the retiring write |
| bufValid | output | 1 | The buffer holds an unretired write |
| lostWriteErr | output | 1 | Sticky: an unretired write was overwritten |

## Verification
The interesting collision is a retire and a capture in the same edge. The held entry must leave on the retire strobe with its old bank, column and data, while the new entry is stored without being counted as an overwrite. The bench provokes this by timing a second write to this device to land exactly on the expiry edge of the first. It then expects two scoreboard items, the old one at that edge and the new one RETIRE_DLY+1 edges later, and it requires the error flag to stay low. The contrasting case, a second write one cycle after the first, must produce only the second item and a set flag.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  typedef enum logic [1:0] {
    OP_NOCOP = 2'b00,
    OP_WR    = 2'b01,
    OP_RD    = 2'b10
  } cmdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // load a new entry this edge
    logic retire;   // emit the held entry this edge
  } ctrlStrobe_t;

endpackage

// File: rtl/wrb_ctrl.sv
module wrb_ctrl
  import wrb_pkg::*;
#(
  parameter int DEV_W      = 3,
  parameter int DEVICE_ID  = 5,
  parameter int RETIRE_DLY = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [DEV_W-1:0] cmdDev,
  output ctrlStrobe_t      strobe,
  output logic             bufValid,
  output logic             lostWriteErr
);

  localparam int CNT_W = $clog2(RETIRE_DLY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RETIRE_DLY);

  logic [CNT_W-1:0] waitCnt;
  logic isOwn, wrOwn, wrOther, rdOwn, expired, doRetire;

  always_comb begin
    isOwn    = (cmdDev == DEV_W'(DEVICE_ID));
    wrOwn    = cmdValid && (cmdOp == OP_WR) && isOwn;
    wrOther  = cmdValid && (cmdOp == OP_WR) && !isOwn;
    rdOwn    = cmdValid && (cmdOp == OP_RD) && isOwn;
    expired  = (waitCnt == '0);
    // a foreign write forces the retire; otherwise wait for expiry
    // in a cycle that carries no read to this device
    doRetire = bufValid && (wrOther || (expired && !rdOwn));
    strobe.capture = wrOwn;
    strobe.retire  = doRetire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid     <= 1'b0;
      waitCnt      <= '0;
      lostWriteErr <= 1'b0;
    end else begin
      bufValid <= wrOwn || (bufValid && !doRetire);
      if (wrOwn && bufValid && !doRetire)
        lostWriteErr <= 1'b1;
      if (wrOwn)
        waitCnt <= CNT_LOAD;
      else if (bufValid && rdOwn)
        waitCnt <= CNT_LOAD;
      else if (bufValid && !expired)
        waitCnt <= waitCnt - 1'b1;
    end
  end

endmodule

// File: rtl/wrb_datapath.sv
module wrb_datapath
  import wrb_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int DATA_W    = 16,
  parameter int MASK_W    = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [$clog2(NUM_BANKS)-1:0] cmdBank,
  input  logic [COL_W-1:0]           cmdCol,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [MASK_W-1:0]          wrMask,
  input  logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic                       retireValid,
  output logic [$clog2(NUM_BANKS)-1:0] retireBank,
  output logic [ROW_W-1:0]           retireRow,
  output logic [COL_W-1:0]           retireCol,
  output logic [DATA_W-1:0]          retireData,
  output logic [MASK_W-1:0]          retireMask
);

  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [ROW_W-1:0]  rowOfBank [NUM_BANKS];
  logic [BANK_W-1:0] heldBank;
  logic [COL_W-1:0]  heldCol;
  logic [DATA_W-1:0] heldData;
  logic [MASK_W-1:0] heldMask;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_rowSlice
    assign rowOfBank[b] = openRows[b*ROW_W +: ROW_W];
  end

  // buffer entry: bank and column only, never a row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldBank <= '0;
      heldCol  <= '0;
      heldData <= '0;
      heldMask <= '0;
    end else if (strobe.capture) begin
      heldBank <= cmdBank;
      heldCol  <= cmdCol;
      heldData <= wrData;
      heldMask <= wrMask;
    end
  end

  // retire port: the row is looked up at retire time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retireValid <= 1'b0;
      retireBank  <= '0;
      retireRow   <= '0;
      retireCol   <= '0;
      retireData  <= '0;
      retireMask  <= '0;
    end else begin
      retireValid <= strobe.retire;
      if (strobe.retire) begin
        retireBank <= heldBank;
        retireRow  <= rowOfBank[heldBank];
        retireCol  <= heldCol;
        retireData <= heldData;
        retireMask <= heldMask;
      end
    end
  end

endmodule

// File: rtl/wr_retire_buf.sv
module wr_retire_buf
  import wrb_pkg::*;
#(
  parameter int DEV_W      = 3,
  parameter int DEVICE_ID  = 5,
  parameter int NUM_BANKS  = 4,
  parameter int ROW_W      = 8,
  parameter int COL_W      = 6,
  parameter int DATA_W     = 16,
  parameter int MASK_W     = 2,
  parameter int RETIRE_DLY = 4,
  localparam int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic [1:0]                 cmdOp,
  input  logic [DEV_W-1:0]           cmdDev,
  input  logic [BANK_W-1:0]          cmdBank,
  input  logic [COL_W-1:0]           cmdCol,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [MASK_W-1:0]          wrMask,
  input  logic [NUM_BANKS*ROW_W-1:0] openRows,
  output logic                       retireValid,
  output logic [BANK_W-1:0]          retireBank,
  output logic [ROW_W-1:0]           retireRow,
  output logic [COL_W-1:0]           retireCol,
  output logic [DATA_W-1:0]          retireData,
  output logic [MASK_W-1:0]          retireMask,
  output logic                       bufValid,
  output logic                       lostWriteErr
);

  ctrlStrobe_t strobe;

  wrb_ctrl #(
    .DEV_W(DEV_W), .DEVICE_ID(DEVICE_ID), .RETIRE_DLY(RETIRE_DLY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdDev(cmdDev), .strobe(strobe), .bufValid(bufValid),
    .lostWriteErr(lostWriteErr)
  );

  wrb_datapath #(
    .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
    .DATA_W(DATA_W), .MASK_W(MASK_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdBank(cmdBank),
    .cmdCol(cmdCol), .wrData(wrData), .wrMask(wrMask),
    .openRows(openRows), .retireValid(retireValid),
    .retireBank(retireBank), .retireRow(retireRow),
    .retireCol(retireCol), .retireData(retireData),
    .retireMask(retireMask)
  );

endmodule

// File: rtl/wrb_checker.sv
module wrb_checker #(
  parameter int DEV_W     = 3,
  parameter int DEVICE_ID = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdValid,
  input logic [1:0]       cmdOp,
  input logic [DEV_W-1:0] cmdDev,
  input logic             retireValid,
  input logic             bufValid,
  input logic             lostWriteErr
);

  logic ownCmd;
  assign ownCmd = (cmdDev == DEV_W'(DEVICE_ID));

  AST_RETIRE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    retireValid |-> $past(bufValid)); // R3

  AST_CAPTURE_SETS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b01 && ownCmd) |=> bufValid); // R2

  AST_READ_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (bufValid && cmdValid && cmdOp == 2'b10 && ownCmd) |=> (!retireValid && bufValid)); // R5

  AST_FOREIGN_WR_FORCES: assert property (@(posedge clk) disable iff (!rstN)
    (bufValid && cmdValid && cmdOp == 2'b01 && !ownCmd) |=> (retireValid && !bufValid)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    lostWriteErr |=> lostWriteErr); // R8

  AST_IDLE_NO_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    !bufValid |=> !retireValid); // R6

endmodule

bind wr_retire_buf wrb_checker #(.DEV_W(DEV_W), .DEVICE_ID(DEVICE_ID)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .cmdDev(cmdDev), .retireValid(retireValid), .bufValid(bufValid),
  .lostWriteErr(lostWriteErr)
);

// File: tb/sim_wr_retire_buf.sv
module sim_wr_retire_buf;

  localparam int DLY = 4;
  localparam logic [2:0] OWN = 3'd5;
  localparam logic [2:0] FOREIGN = 3'd2;
  localparam logic [1:0] NOP = 2'b00, WR = 2'b01, RD = 2'b10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [2:0] cmdDev = '0;
  logic [1:0] cmdBank = '0;
  logic [5:0] cmdCol = '0;
  logic [15:0] wrData = '0;
  logic [1:0] wrMask = '0;
  logic [31:0] openRows = 32'h33221100;
  logic retireValid, bufValid, lostWriteErr;
  logic [1:0] retireBank, retireMask;
  logic [7:0] retireRow;
  logic [5:0] retireCol;
  logic [15:0] retireData;

  int errors = 0;
  int checks = 0;
  int edgeN = 0;
  int lastEdge = 0;

  typedef struct packed {
    logic [31:0] atEdge;
    logic [7:0]  req;
    logic [1:0]  bank;
    logic [5:0]  col;
    logic [7:0]  row;
    logic [15:0] data;
    logic [1:0]  mask;
  } expItem_t;

  expItem_t expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) edgeN <= edgeN + 1;

  wr_retire_buf #(.DEVICE_ID(5), .RETIRE_DLY(DLY)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdDev(cmdDev), .cmdBank(cmdBank), .cmdCol(cmdCol), .wrData(wrData),
    .wrMask(wrMask), .openRows(openRows), .retireValid(retireValid),
    .retireBank(retireBank), .retireRow(retireRow), .retireCol(retireCol),
    .retireData(retireData), .retireMask(retireMask), .bufValid(bufValid),
    .lostWriteErr(lostWriteErr)
  );

  // monitor: pops the scoreboard on every retire strobe
  always @(negedge clk) begin
    if (rstN && retireValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected retire at edge %0d: bank=%0d col=%0d data=%h, expected none (R3/R6/R8)",
                 edgeN, retireBank, retireCol, retireData);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (e.atEdge != edgeN || e.bank != retireBank || e.col != retireCol ||
            e.row != retireRow || e.data != retireData || e.mask != retireMask) begin
          errors++;
          $display("FAIL R%0d retire: edge=%0d bank=%0d col=%0d row=%h data=%h mask=%b, expected edge=%0d bank=%0d col=%0d row=%h data=%h mask=%b",
                   e.req, edgeN, retireBank, retireCol, retireRow, retireData, retireMask,
                   e.atEdge, e.bank, e.col, e.row, e.data, e.mask);
        end
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [2:0] dev, input logic [1:0] bank,
                       input logic [5:0] col, input logic [15:0] data, input logic [1:0] mask);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdDev = dev; cmdBank = bank;
    cmdCol = col; wrData = data; wrMask = mask;
    lastEdge = edgeN + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmdValid = 1'b0; cmdOp = NOP;
    end
  endtask

  task automatic push(input int at, input int req, input logic [1:0] bank, input logic [5:0] col,
                      input logic [7:0] row, input logic [15:0] data, input logic [1:0] mask);
    expItem_t e;
    e.atEdge = 32'(at); e.req = 8'(req); e.bank = bank; e.col = col;
    e.row = row; e.data = data; e.mask = mask;
    expQ.push_back(e);
  endtask

  task automatic checkBit(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=done");
    summary();
  end

  initial begin
    int capE;
    // R1: reset state
    repeat (3) @(negedge clk);
    checkBit("R1 bufValid in reset", bufValid, 1'b0);
    checkBit("R1 retireValid in reset", retireValid, 1'b0);
    rstN = 1'b1;
    idle(2);
    checkBit("R1 bufValid after reset", bufValid, 1'b0);
    checkBit("R1 lostWriteErr after reset", lostWriteErr, 1'b0);

    // R2 / R3: plain write, retire after the fixed delay
    issue(WR, OWN, 2'd1, 6'd10, 16'hA1A1, 2'b01);
    push(lastEdge + DLY + 1, 3, 2'd1, 6'd10, 8'h11, 16'hA1A1, 2'b01);
    idle(1);
    checkBit("R2 bufValid after capture", bufValid, 1'b1);
    idle(6);
    checkBit("R3 bufValid after retire", bufValid, 1'b0);

    // R4: row changes between write and retire
    issue(WR, OWN, 2'd2, 6'd3, 16'hB2B2, 2'b10);
    capE = lastEdge;
    idle(2);
    openRows[23:16] = 8'h2C;
    push(capE + DLY + 1, 4, 2'd2, 6'd3, 8'h2C, 16'hB2B2, 2'b10);
    idle(7);

    // R5: six reads to this device, any bank and column, hold the retire off
    issue(WR, OWN, 2'd3, 6'd7, 16'hC3C3, 2'b11);
    for (int k = 0; k < 6; k++) begin
      idle(1);
      issue(RD, OWN, 2'(k), 6'(k * 9), 16'h0, 2'b00);
    end
    push(lastEdge + DLY + 1, 5, 2'd3, 6'd7, 8'h33, 16'hC3C3, 2'b11);
    idle(1);
    checkBit("R5 bufValid while reads continue", bufValid, 1'b1);
    idle(7);
    checkBit("R5 bufValid after held-off retire", bufValid, 1'b0);

    // R6: foreign read and no-op do not delay
    issue(WR, OWN, 2'd0, 6'd20, 16'hD4D4, 2'b01);
    push(lastEdge + DLY + 1, 6, 2'd0, 6'd20, 8'h00, 16'hD4D4, 2'b01);
    idle(1);
    issue(RD, FOREIGN, 2'd0, 6'd1, 16'h0, 2'b00);
    issue(NOP, OWN, 2'd0, 6'd2, 16'h0, 2'b00);
    idle(8);

    // R7: write to another device forces retire
    openRows[7:0] = 8'h40;
    issue(WR, OWN, 2'd0, 6'd5, 16'hE5E5, 2'b10);
    idle(1);
    issue(WR, FOREIGN, 2'd1, 6'd6, 16'hFFFF, 2'b11);
    push(lastEdge, 7, 2'd0, 6'd5, 8'h40, 16'hE5E5, 2'b10);
    idle(1);
    checkBit("R7 bufValid after forced retire", bufValid, 1'b0);
    idle(6);

    // R9: new write lands on the expiry edge of the old one
    issue(WR, OWN, 2'd1, 6'd1, 16'h1111, 2'b01);
    push(lastEdge + DLY + 1, 9, 2'd1, 6'd1, 8'h11, 16'h1111, 2'b01);
    idle(DLY);
    issue(WR, OWN, 2'd2, 6'd2, 16'h2222, 2'b10);
    push(lastEdge + DLY + 1, 9, 2'd2, 6'd2, 8'h2C, 16'h2222, 2'b10);
    idle(1);
    checkBit("R9 no error on coincident retire and capture", lostWriteErr, 1'b0);
    checkBit("R9 new entry held", bufValid, 1'b1);
    idle(7);

    // R8: overwrite before retire loses the first write
    issue(WR, OWN, 2'd3, 6'd11, 16'h5555, 2'b01);
    issue(WR, OWN, 2'd3, 6'd12, 16'h6666, 2'b10);
    push(lastEdge + DLY + 1, 8, 2'd3, 6'd12, 8'h33, 16'h6666, 2'b10);
    idle(1);
    checkBit("R8 lostWriteErr set", lostWriteErr, 1'b1);
    idle(8);
    checkBit("R8 lostWriteErr sticky", lostWriteErr, 1'b1);

    // R1: reset discards a pending write and clears the flag
    issue(WR, OWN, 2'd1, 6'd30, 16'h7777, 2'b11);
    idle(1);
    rstN = 1'b0;
    idle(2);
    checkBit("R1 bufValid cleared by reset", bufValid, 1'b0);
    rstN = 1'b1;
    idle(8);
    checkBit("R1 lostWriteErr cleared by reset", lostWriteErr, 1'b0);
    checkBit("R1 no entry after reset", bufValid, 1'b0);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R3 missing retires: actual=%0d pending expected=0", expQ.size());
    end
    summary();
  end

endmodule